// File: doc/BRIEF.md
# Host Bus DMA Handshake Controller

This block is the host-facing front end of a peripheral that sits on an 8-bit ISA-style I/O bus. It watches the active-low read and write strobes, captures the 11-bit I/O address when a strobe starts, and turns decoded accesses into single-cycle register strobes for the peripheral core. It also drives the byte-wide data bus through a split output/enable pair. An address-enable input marks DMA cycles, and while it is high every address decode is suppressed.

The block also runs one byte-wide DMA channel. When the core has armed the channel and signals that it needs a byte, the block raises an active-high request. The active-low acknowledge routes strobes straight to the core's DMA byte ports, with no address decode. On the final byte the request drops at the acknowledge falling edge. In demand transfers, where acknowledge is already low, it drops at the read-strobe falling edge instead. A terminal count, whose polarity depends on the operating mode and which counts only while acknowledge is low, ends the transfer. The block then emits a one-cycle done pulse and keeps the request low until the core re-arms the channel.

All bus inputs pass through a two-flop synchronizer, and strobe edges are taken from the synchronized levels. Registered results therefore appear on the third clock edge after a bus input changes.

Top module: `hostbus_dma_ctl`

## Requirements
- R1: A register access is decoded only when all 11 address bits match the register window: with the default base 11'h3F0 and 8 registers, an access hits when address bits [10:3] equal 8'h7E, and address bits [2:0] become the register index. Any other address produces no register strobe.
- R2: The address is captured at the leading (falling) edge of a read or write strobe. The register index and the read data stay on that captured value for the whole cycle, even if the address lines change afterwards.
- R3: While address enable is high, neither a read nor a write strobe produces a register strobe, and the data bus is not driven.
- R4: The data bus enable is high only during a decoded register read or a DMA read, and it returns low once the read strobe ends. During a register read the bus carries the core's register read data. During a DMA read it carries the core's DMA read byte.
- R5: A decoded write produces exactly one register write strobe, with the captured index and the byte that was present on the data bus.
- R6: The DMA request is high while the channel is armed, the core needs a byte and acknowledge is high. It stays low while the channel is unarmed.
- R7: With the last-byte input high, the request clears at the acknowledge falling edge.
- R8: When acknowledge is already low (demand transfer), the request stays high across non-final bytes. It clears at the read-strobe falling edge once the last-byte input is high.
- R9: While acknowledge is low, a read strobe yields one DMA take strobe and a write strobe yields one DMA put strobe carrying the bus byte. Neither depends on address or address enable, and neither produces a register strobe.
- R10: Terminal count has no effect while acknowledge is high.
- R11: Terminal count is active high in modes 2'b00, 2'b01 and 2'b11, and active low in mode 2'b10.
- R12: A terminal count seen while acknowledge is low and the channel is armed produces exactly one done pulse. It then holds the request low until the channel is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | I/O address lines |
| bus_ior_n | input | 1 | Active-low read strobe |
| bus_iow_n | input | 1 | Active-low write strobe |
| bus_aen | input | 1 | Address enable, high during DMA cycles |
| bus_d_i | input | 8 | Data bus value seen from the bus |
| bus_d_o | output | 8 | Data the block drives onto the bus |
| bus_d_oe | output | 1 | Data bus output enable (high-impedance when low) |
| bus_mode | input | 2 | Operating mode, selects terminal-count polarity |
| dma_req | output | 1 | Active-high DMA request |
| dma_ack_n | input | 1 | Active-low DMA acknowledge |
| dma_tc | input | 1 | Terminal count |
| reg_idx | output | 3 | Captured register index |
| reg_rd_stb | output | 1 | One-cycle register read strobe |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Byte written to the register |
| reg_rdata | input | 8 | Register read data from the core |
| chan_arm | input | 1 | One-cycle pulse that arms the channel |
| chan_need | input | 1 | Core needs a byte transferred |
| chan_last | input | 1 | Pending byte is the final one |
| dma_rdata | input | 8 | DMA read byte from the core |
| dma_take_stb | output | 1 | One-cycle DMA read strobe to the core |
| dma_put_stb | output | 1 | One-cycle DMA write strobe to the core |
| dma_wdata | output | 8 | Byte captured on a DMA write |
| chan_done | output | 1 | One-cycle terminal-count pulse |

## Verification
Every registered result appears on the third rising edge after the bus input that caused it: two synchronizer flops plus the edge-detect register. The core-side request update follows one edge after its input. For level outputs (bus enable, bus data, request, index), the bench changes an input just after a rising edge, waits five edges, and samples at the falling edge, so every check falls inside the settled window. One-cycle strobes and done pulses are counted by a monitor at every rising edge. Each check compares the change in the count, together with the byte and index that were latched when the pulse was seen, against the value computed from the stimulus.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_AT   = 2'b00,
        MODE_M30  = 2'b01,
        MODE_TCLO = 2'b10,
        MODE_RSV  = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'b00,
        CYC_IO   = 2'b01,
        CYC_DMA  = 2'b10
    } cyc_kind_e;

    typedef struct packed {
        logic armed;
        logic drq;
    } chan_state_t;

    // Terminal count level that counts as "asserted" for the given mode.
    function automatic logic tc_asserted(input bus_mode_e m, input logic tc_lvl);
        return (m == MODE_TCLO) ? ~tc_lvl : tc_lvl;
    endfunction

    // Full-width compare: every bit above the register select field must match.
    function automatic logic addr_hits(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned low_bits);
        logic [ADDR_W-1:0] diff;
        diff = (a ^ base) >> low_bits;
        return diff == '0;
    endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbd_io_port.sv
module hbd_io_port
    import hbd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h3F0,
    parameter int                SEL_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ior_s,
    input  logic              aen_s,
    input  logic              dack_s,
    input  logic              ior_fall,
    input  logic              iow_fall,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_d_i,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] dma_rdata,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_d_oe,
    output logic [SEL_W-1:0]  reg_idx,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              dma_take_stb,
    output logic              dma_put_stb,
    output logic [DATA_W-1:0] dma_wdata
);

    cyc_kind_e rd_kind;
    logic      hit;

    assign hit = addr_hits(bus_addr, BASE_ADDR, SEL_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_kind      <= CYC_IDLE;
            reg_idx      <= '0;
            reg_rd_stb   <= 1'b0;
            reg_wr_stb   <= 1'b0;
            reg_wdata    <= '0;
            dma_take_stb <= 1'b0;
            dma_put_stb  <= 1'b0;
            dma_wdata    <= '0;
        end else begin
            reg_rd_stb   <= 1'b0;
            reg_wr_stb   <= 1'b0;
            dma_take_stb <= 1'b0;
            dma_put_stb  <= 1'b0;

            // Read side: acknowledge routes to the DMA path ahead of any decode.
            if (ior_fall) begin
                if (!dack_s) begin
                    rd_kind      <= CYC_DMA;
                    dma_take_stb <= 1'b1;
                end else if (!aen_s && hit) begin
                    rd_kind    <= CYC_IO;
                    reg_rd_stb <= 1'b1;
                    reg_idx    <= bus_addr[SEL_W-1:0];
                end
            end else if (ior_s) begin
                rd_kind <= CYC_IDLE;
            end

            // Write side
            if (iow_fall) begin
                if (!dack_s) begin
                    dma_put_stb <= 1'b1;
                    dma_wdata   <= bus_d_i;
                end else if (!aen_s && hit) begin
                    reg_wr_stb <= 1'b1;
                    reg_idx    <= bus_addr[SEL_W-1:0];
                    reg_wdata  <= bus_d_i;
                end
            end
        end
    end

    assign bus_d_oe = (rd_kind != CYC_IDLE);
    assign bus_d_o  = (rd_kind == CYC_DMA) ? dma_rdata : reg_rdata;

endmodule

// File: rtl/hbd_dma_chan.sv
module hbd_dma_chan
    import hbd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode,
    input  logic      dack_s,
    input  logic      dack_fall,
    input  logic      ior_fall,
    input  logic      tc_s,
    input  logic      chan_arm,
    input  logic      chan_need,
    input  logic      chan_last,
    output logic      dma_req,
    output logic      chan_done,
    output logic      armed
);

    chan_state_t st, nx;
    logic        done_nx;
    logic        tc_hit;

    assign tc_hit = !dack_s && tc_asserted(mode, tc_s);

    always_comb begin
        nx      = st;
        done_nx = 1'b0;
        if (chan_arm) nx.armed = 1'b1;

        if (dack_fall) begin
            if (chan_last) nx.drq = 1'b0;
        end else if (!dack_s) begin
            if (ior_fall && chan_last) nx.drq = 1'b0;
        end else begin
            nx.drq = nx.armed && chan_need;
        end

        if (st.armed && tc_hit) begin
            nx.armed = 1'b0;
            nx.drq   = 1'b0;
            done_nx  = 1'b1;
        end

        if (!nx.armed) nx.drq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            chan_done <= 1'b0;
        end else begin
            st        <= nx;
            chan_done <= done_nx;
        end
    end

    assign dma_req = st.drq;
    assign armed   = st.armed;

endmodule

// File: rtl/hostbus_dma_ctl.sv
module hostbus_dma_ctl
    import hbd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 11'h3F0,
    parameter int                REG_SEL_W   = 3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_ior_n,
    input  logic                 bus_iow_n,
    input  logic                 bus_aen,
    input  logic [DATA_W-1:0]    bus_d_i,
    output logic [DATA_W-1:0]    bus_d_o,
    output logic                 bus_d_oe,
    input  logic [1:0]           bus_mode,
    output logic                 dma_req,
    input  logic                 dma_ack_n,
    input  logic                 dma_tc,
    output logic [REG_SEL_W-1:0] reg_idx,
    output logic                 reg_rd_stb,
    output logic                 reg_wr_stb,
    output logic [DATA_W-1:0]    reg_wdata,
    input  logic [DATA_W-1:0]    reg_rdata,
    input  logic                 chan_arm,
    input  logic                 chan_need,
    input  logic                 chan_last,
    input  logic [DATA_W-1:0]    dma_rdata,
    output logic                 dma_take_stb,
    output logic                 dma_put_stb,
    output logic [DATA_W-1:0]    dma_wdata,
    output logic                 chan_done
);

    localparam int               NSYNC    = 5;
    // bit order: read strobe, write strobe, address enable, acknowledge, terminal count
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b11010;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic             ior_s, iow_s, aen_s, dack_s, tc_s;
    logic [2:0]       strb_q;
    logic             ior_fall, iow_fall, dack_fall;
    logic             chan_armed;

    assign raw_in = {bus_ior_n, bus_iow_n, bus_aen, dma_ack_n, dma_tc};

    hbd_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_in),
        .q  (sync_out)
    );

    assign {ior_s, iow_s, aen_s, dack_s, tc_s} = sync_out;

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 3'b111;
        else     strb_q <= {ior_s, iow_s, dack_s};
    end

    assign ior_fall  = strb_q[2] & ~ior_s;
    assign iow_fall  = strb_q[1] & ~iow_s;
    assign dack_fall = strb_q[0] & ~dack_s;

    hbd_io_port #(
        .BASE_ADDR(BASE_ADDR),
        .SEL_W    (REG_SEL_W)
    ) u_io (
        .clk         (clk),
        .rst         (rst),
        .ior_s       (ior_s),
        .aen_s       (aen_s),
        .dack_s      (dack_s),
        .ior_fall    (ior_fall),
        .iow_fall    (iow_fall),
        .bus_addr    (bus_addr),
        .bus_d_i     (bus_d_i),
        .reg_rdata   (reg_rdata),
        .dma_rdata   (dma_rdata),
        .bus_d_o     (bus_d_o),
        .bus_d_oe    (bus_d_oe),
        .reg_idx     (reg_idx),
        .reg_rd_stb  (reg_rd_stb),
        .reg_wr_stb  (reg_wr_stb),
        .reg_wdata   (reg_wdata),
        .dma_take_stb(dma_take_stb),
        .dma_put_stb (dma_put_stb),
        .dma_wdata   (dma_wdata)
    );

    hbd_dma_chan u_chan (
        .clk      (clk),
        .rst      (rst),
        .mode     (bus_mode_e'(bus_mode)),
        .dack_s   (dack_s),
        .dack_fall(dack_fall),
        .ior_fall (ior_fall),
        .tc_s     (tc_s),
        .chan_arm (chan_arm),
        .chan_need(chan_need),
        .chan_last(chan_last),
        .dma_req  (dma_req),
        .chan_done(chan_done),
        .armed    (chan_armed)
    );

endmodule

// File: rtl/hbd_checks.sv
module hbd_checks (
    input logic clk,
    input logic rst,
    input logic bus_d_oe,
    input logic ior_s,
    input logic aen_s,
    input logic dack_s,
    input logic reg_rd_stb,
    input logic reg_wr_stb,
    input logic dma_req,
    input logic chan_done,
    input logic chan_armed
);

    // R4: bus only driven while the synchronized read strobe was low
    a_r4_oe_only_in_read: assert property (@(posedge clk) disable iff (rst)
        bus_d_oe |-> !$past(ior_s));

    // R3: no register strobe from a cycle with address enable high
    a_r3_aen_blocks_decode: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_stb || reg_wr_stb) |-> !$past(aen_s));

    // R9: acknowledge low routes strobes away from register decode
    a_r9_ack_bypasses_decode: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_stb || reg_wr_stb) |-> $past(dack_s));

    // R10: terminal count only counts with acknowledge low
    a_r10_tc_needs_ack: assert property (@(posedge clk) disable iff (rst)
        chan_done |-> !$past(dack_s));

    // R12: done drops the request and disarms
    a_r12_done_drops_req: assert property (@(posedge clk) disable iff (rst)
        chan_done |-> (!dma_req && !chan_armed));

    // R12: done is a single-cycle pulse
    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        chan_done |=> !chan_done);

endmodule

bind hostbus_dma_ctl hbd_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_d_oe  (bus_d_oe),
    .ior_s     (ior_s),
    .aen_s     (aen_s),
    .dack_s    (dack_s),
    .reg_rd_stb(reg_rd_stb),
    .reg_wr_stb(reg_wr_stb),
    .dma_req   (dma_req),
    .chan_done (chan_done),
    .chan_armed(chan_armed)
);

// File: tb/test_hostbus_dma_ctl.sv
module test_hostbus_dma_ctl;

    localparam int          CLK_P    = 10;
    localparam logic [10:0] BASE     = 11'h3F0;
    localparam int          WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] bus_addr = '0;
    logic        bus_ior_n = 1'b1, bus_iow_n = 1'b1, bus_aen = 1'b0;
    logic [7:0]  bus_d_i = '0;
    logic [7:0]  bus_d_o;
    logic        bus_d_oe;
    logic [1:0]  bus_mode = 2'b00;
    logic        dma_req;
    logic        dma_ack_n = 1'b1, dma_tc = 1'b0;
    logic [2:0]  reg_idx;
    logic        reg_rd_stb, reg_wr_stb;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        chan_arm = 1'b0, chan_need = 1'b0, chan_last = 1'b0;
    logic [7:0]  dma_rdata = 8'h9C;
    logic        dma_take_stb, dma_put_stb;
    logic [7:0]  dma_wdata;
    logic        chan_done;

    int n_checks = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_take = 0, n_put = 0, n_done = 0;
    logic [7:0] seen_wdata = '0, seen_dwdata = '0;
    logic [2:0] seen_widx = '0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] reg_val(input logic [2:0] idx);
        return 8'h40 + 8'(idx) * 8'd7;
    endfunction

    assign reg_rdata = reg_val(reg_idx);

    hostbus_dma_ctl i_hostbus_dma_ctl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_ior_n(bus_ior_n),
        .bus_iow_n(bus_iow_n), .bus_aen(bus_aen), .bus_d_i(bus_d_i),
        .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe), .bus_mode(bus_mode),
        .dma_req(dma_req), .dma_ack_n(dma_ack_n), .dma_tc(dma_tc),
        .reg_idx(reg_idx), .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_arm(chan_arm),
        .chan_need(chan_need), .chan_last(chan_last), .dma_rdata(dma_rdata),
        .dma_take_stb(dma_take_stb), .dma_put_stb(dma_put_stb),
        .dma_wdata(dma_wdata), .chan_done(chan_done)
    );

    // Pulse monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (reg_rd_stb)   n_rd++;
            if (reg_wr_stb) begin n_wr++; seen_wdata = reg_wdata; seen_widx = reg_idx; end
            if (dma_take_stb) n_take++;
            if (dma_put_stb) begin n_put++; seen_dwdata = dma_wdata; end
            if (chan_done)    n_done++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic arm_pulse();
        chan_arm = 1'b1;
        cyc(1);
        chan_arm = 1'b0;
        cyc(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base_rd, base_wr, base_take, base_put, base_done;
        logic hit;
        logic inact;

        cyc(4);
        rst = 1'b0;
        cyc(5);
        @(negedge clk);
        chk("R4 reset oe", bus_d_oe, 0);
        chk("R6 reset req", dma_req, 0);
        chk("R12 reset done", n_done, 0);

        // R1 R2 R4: read sweep over every address with address enable low
        for (int a = 0; a < 2048; a++) begin
            bus_addr = 11'(a);
            bus_aen  = 1'b0;
            cyc(1);
            base_rd = n_rd;
            bus_ior_n = 1'b0;
            cyc(5);
            hit = ((11'(a) >> 3) == (BASE >> 3));
            @(negedge clk);
            chk("R1 read strobe count", n_rd - base_rd, hit ? 1 : 0);
            chk("R4 oe during read", bus_d_oe, hit ? 1 : 0);
            if (hit) begin
                chk("R4 register data", bus_d_o, reg_val(3'(a)));
                bus_addr = ~11'(a);
                cyc(2);
                @(negedge clk);
                chk("R2 held index", reg_idx, a & 7);
                chk("R2 held data", bus_d_o, reg_val(3'(a)));
            end
            bus_ior_n = 1'b1;
            cyc(5);
            @(negedge clk);
            chk("R4 oe after read", bus_d_oe, 0);
        end

        // R3: writes to every address with address enable high
        bus_aen = 1'b1;
        for (int a = 0; a < 2048; a++) begin
            bus_addr = 11'(a);
            bus_d_i  = 8'(a);
            cyc(1);
            base_wr = n_wr;
            bus_iow_n = 1'b0;
            cyc(4);
            bus_iow_n = 1'b1;
            cyc(4);
            chk("R3 aen write suppressed", n_wr - base_wr, 0);
        end

        // R3: reads of the register window with address enable high
        for (int r = 0; r < 8; r++) begin
            bus_addr = BASE + 11'(r);
            cyc(1);
            base_rd = n_rd;
            bus_ior_n = 1'b0;
            cyc(5);
            @(negedge clk);
            chk("R3 aen read no oe", bus_d_oe, 0);
            chk("R3 aen read no strobe", n_rd - base_rd, 0);
            bus_ior_n = 1'b1;
            cyc(4);
        end
        bus_aen = 1'b0;

        // R5: register writes in the window
        for (int r = 0; r < 8; r++) begin
            bus_addr = BASE + 11'(r);
            bus_d_i  = 8'(r) ^ 8'hC3;
            cyc(1);
            base_wr = n_wr;
            bus_iow_n = 1'b0;
            cyc(5);
            bus_iow_n = 1'b1;
            cyc(4);
            chk("R5 write strobe count", n_wr - base_wr, 1);
            chk("R5 write data", seen_wdata, r ^ 8'hC3);
            chk("R5 write index", seen_widx, r);
        end

        // R6: need without arming leaves request low
        bus_mode  = 2'b00;
        dma_tc    = 1'b0;
        chan_need = 1'b1;
        cyc(5);
        @(negedge clk);
        chk("R6 unarmed req low", dma_req, 0);
        arm_pulse();
        cyc(2);
        @(negedge clk);
        chk("R6 armed req high", dma_req, 1);

        // R8: demand transfer, acknowledge stays low
        chan_last = 1'b0;
        bus_aen   = 1'b1;
        bus_addr  = BASE;
        dma_ack_n = 1'b0;
        cyc(5);
        @(negedge clk);
        chk("R8 non-last keeps req", dma_req, 1);
        for (int b = 0; b < 3; b++) begin
            base_take = n_take;
            base_rd   = n_rd;
            dma_rdata = 8'h90 + 8'(b);
            bus_ior_n = 1'b0;
            cyc(5);
            @(negedge clk);
            chk("R9 DMA read oe", bus_d_oe, 1);
            chk("R9 DMA read data", bus_d_o, 8'h90 + b);
            chk("R9 take strobe", n_take - base_take, 1);
            chk("R9 no register strobe", n_rd - base_rd, 0);
            chk("R8 req during demand", dma_req, 1);
            bus_ior_n = 1'b1;
            cyc(5);
        end
        chan_last = 1'b1;
        cyc(2);
        bus_ior_n = 1'b0;
        cyc(5);
        @(negedge clk);
        chk("R8 last read clears req", dma_req, 0);
        bus_ior_n = 1'b1;
        cyc(4);
        dma_ack_n = 1'b1;
        cyc(5);
        @(negedge clk);
        chk("R6 req returns", dma_req, 1);

        // R7: single-byte transfer, last byte at acknowledge fall
        dma_ack_n = 1'b0;
        cyc(5);
        @(negedge clk);
        chk("R7 ack fall clears req", dma_req, 0);
        // R9: DMA write with unrelated address and aen low
        bus_aen  = 1'b0;
        bus_addr = 11'h123;
        bus_d_i  = 8'hA5;
        base_put = n_put;
        base_wr  = n_wr;
        bus_iow_n = 1'b0;
        cyc(5);
        bus_iow_n = 1'b1;
        cyc(4);
        chk("R9 put strobe", n_put - base_put, 1);
        chk("R9 put data", seen_dwdata, 8'hA5);
        chk("R9 no register write", n_wr - base_wr, 0);
        dma_ack_n = 1'b1;
        chan_last = 1'b0;
        cyc(5);

        // R10 R11 R12: terminal count in every mode
        for (int m = 0; m < 4; m++) begin
            inact    = (m == 2);
            bus_mode = 2'(m);
            dma_tc   = inact;
            cyc(5);
            arm_pulse();
            cyc(2);
            @(negedge clk);
            chk("R6 armed in mode", dma_req, 1);
            base_done = n_done;
            dma_tc = ~inact;
            cyc(6);
            @(negedge clk);
            chk("R10 tc ignored ack high", n_done - base_done, 0);
            chk("R10 req kept ack high", dma_req, 1);
            dma_ack_n = 1'b0;
            cyc(5);
            @(negedge clk);
            chk("R11 tc polarity done", n_done - base_done, 1);
            chk("R12 done drops req", dma_req, 0);
            cyc(6);
            chk("R12 single done pulse", n_done - base_done, 1);
            dma_ack_n = 1'b1;
            dma_tc    = inact;
            cyc(6);
            @(negedge clk);
            chk("R12 req held until rearm", dma_req, 0);
        end

        // R11: inactive level in the low-active mode does not end a transfer
        bus_mode = 2'b10;
        dma_tc   = 1'b1;
        cyc(4);
        arm_pulse();
        base_done = n_done;
        dma_ack_n = 1'b0;
        cyc(6);
        @(negedge clk);
        chk("R11 high tc inactive in low mode", n_done - base_done, 0);
        chk("R11 req kept non-last", dma_req, 1);
        dma_ack_n = 1'b1;
        cyc(4);

        finish_run();
    end

endmodule